// File: doc/BRIEF.md
# PHY Address Discovery Scanner

This block locates the first management-bus PHY that answers and reads its 32-bit identifier. A one-cycle start pulse launches a scan. The scanner asks an external MDIO serial engine for register reads through a small request/response port. Each request carries a PHY address and a register number. The engine answers with a done pulse and the read data.

Addresses are probed from the lowest to the highest. A read that returns all ones is taken to mean that nothing sits at that address. The first address that returns any other value ends the scan. The scanner then makes one more read at that address to fetch the upper half of the identifier.

If a whole pass over every address finds nothing, the scanner waits a fixed time and tries again, up to a set number of passes. The wait gives slow PHYs time to come out of reset. At the end, the scanner pulses done and presents one of two results: a found flag with the address and identifier, or a not-found result.

Top module: `phy_scan`

## Requirements
- R1: After reset, busy, done, found and rd_req are 0. An accepted start raises busy on the next cycle. Busy stays high until the cycle in which done pulses, and done is high for exactly one cycle.
- R2: A start pulse that arrives while busy is high is ignored. The scan in progress continues from its current address and does not return to address 0.
- R3: Within a pass, probe reads go to addresses 0, 1, 2 and so on upward to 31, one after the other. Each probe reads register number 3 first.
- R4: A probe that returns 16'hFFFF means the address is empty, and the scan moves to the next address. Any other value ends the probing, and no higher address is read.
- R5: After a hit, the next read goes to register number 2 at the same address. phy_id is {register 2 value, register 3 value}, with the register 2 value in bits 31:16.
- R6: If no hit is seen in MAX_PASSES passes, the scan makes exactly MAX_PASSES×32 probe reads. It then ends with found=0, phy_addr=5'h1F and phy_id=0.
- R7: Before every pass after the first, no request is issued for at least WAIT_CYCLES cycles after the last response of the previous pass. The request that opens the new pass appears no later than WAIT_CYCLES+4 cycles after that response.
- R8: The first pass has no wait. The cycle after an accepted start carries rd_req=1 with rd_phy=0 and rd_reg=3.
- R9: When both a lower and a higher address would respond, found=1 and phy_addr is the lower one. The same holds for a PHY that first answers on a later pass. found, phy_addr and phy_id keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle scan start pulse |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| found | output | 1 | A PHY answered in the last scan |
| phy_addr | output | 5 | Address of the found PHY, all ones if none |
| phy_id | output | 32 | Identifier {reg2, reg3}, zero if none |
| rd_req | output | 1 | One-cycle read request to the MDIO engine |
| rd_phy | output | 5 | PHY address of the request, held until the response |
| rd_reg | output | 5 | Register number of the request, held until the response |
| rd_done | input | 1 | Read response strobe from the MDIO engine |
| rd_data | input | 16 | Read data, valid with rd_done |

## Verification
A wrong address counter or a wrong pass counter shows up at rd_phy on the very next request. The bench logs every request, so a skipped, repeated or restarted address is caught within one probe.

A wrong decision on the all-ones value shows up in one of two ways. Either extra probes appear past the hit, or the register-2 read is missing. Both differences appear in the request log before done.

A fault in the wait counter changes the gap between the last response of one pass and the first request of the next. That gap is measured on every pass boundary.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_PROBE_LO = 2'd1,
    ST_PROBE_HI = 2'd2,
    ST_DELAY    = 2'd3
  } scan_state_t;

  localparam logic [4:0]  REG_ID_HI = 5'd2;
  localparam logic [4:0]  REG_ID_LO = 5'd3;
  localparam logic [15:0] ABSENT_VAL = 16'hFFFF;
endpackage

// File: rtl/phy_scan_delay.sv
module phy_scan_delay #(
  parameter int WAIT_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CNT_W = $clog2(WAIT_CYCLES + 1) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (load) begin
        cnt_q <= CNT_W'(WAIT_CYCLES - 1);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == '0) begin
          run_q   <= 1'b0;
          expired <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assert_expire_single_R7: assert property (@(posedge clk) disable iff (rst)
    expired |=> !expired);
endmodule

// File: rtl/phy_scan_ctrl.sv
module phy_scan_ctrl
  import phy_scan_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int MAX_PASSES  = 11,
  parameter int WAIT_CYCLES = 1250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              expired,
  output logic              load_wait,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [31:0]       phy_id,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_phy,
  output logic [4:0]        rd_reg,
  input  logic              rd_done,
  input  logic [15:0]       rd_data
);
  localparam int PASS_W = $clog2(MAX_PASSES + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam int GAP_W = $clog2(WAIT_CYCLES + 2) + 1;

  scan_state_t       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PASS_W-1:0] pass_q;
  logic [15:0]       id_lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      pass_q    <= '0;
      id_lo_q   <= '0;
      load_wait <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      found     <= 1'b0;
      phy_addr  <= '1;
      phy_id    <= '0;
      rd_req    <= 1'b0;
      rd_phy    <= '0;
      rd_reg    <= REG_ID_LO;
    end else begin
      rd_req    <= 1'b0;
      done      <= 1'b0;
      load_wait <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          busy     <= 1'b1;
          found    <= 1'b0;
          phy_addr <= '1;
          phy_id   <= '0;
          addr_q   <= '0;
          pass_q   <= PASS_W'(1);
          rd_req   <= 1'b1;
          rd_phy   <= '0;
          rd_reg   <= REG_ID_LO;
          state_q  <= ST_PROBE_LO;
        end
        ST_PROBE_LO: if (rd_done) begin
          if (rd_data != ABSENT_VAL) begin
            id_lo_q <= rd_data;
            rd_req  <= 1'b1;
            rd_reg  <= REG_ID_HI;
            state_q <= ST_PROBE_HI;
          end else if (addr_q != LAST_ADDR) begin
            addr_q <= addr_q + 1'b1;
            rd_req <= 1'b1;
            rd_phy <= addr_q + 1'b1;
            rd_reg <= REG_ID_LO;
          end else if (pass_q == PASS_W'(MAX_PASSES)) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            pass_q    <= pass_q + 1'b1;
            addr_q    <= '0;
            load_wait <= 1'b1;
            state_q   <= ST_DELAY;
          end
        end
        ST_PROBE_HI: if (rd_done) begin
          phy_id   <= {rd_data, id_lo_q};
          phy_addr <= addr_q;
          found    <= 1'b1;
          busy     <= 1'b0;
          done     <= 1'b1;
          state_q  <= ST_IDLE;
        end
        ST_DELAY: if (expired) begin
          rd_req  <= 1'b1;
          rd_phy  <= '0;
          rd_reg  <= REG_ID_LO;
          state_q <= ST_PROBE_LO;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Checker state, separate from the control path
  logic [ADDR_W-1:0] chk_last_q;
  logic [GAP_W-1:0]  chk_gap_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_last_q <= '0;
      chk_gap_q  <= '0;
    end else begin
      if (rd_req) chk_last_q <= rd_phy;
      if (state_q != ST_DELAY) chk_gap_q <= '0;
      else if (chk_gap_q != '1) chk_gap_q <= chk_gap_q + 1'b1;
    end
  end

  assert_busy_from_start_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (rst)
    busy && !done && !$past(done) && start |=> busy || done);
  assert_ascending_R3: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_reg == REG_ID_LO && rd_phy != '0 |-> rd_phy == ADDR_W'(chk_last_q + 1'b1));
  assert_hi_same_addr_R5: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_reg == REG_ID_HI |-> rd_phy == chk_last_q);
  assert_pass_gap_R7: assert property (@(posedge clk) disable iff (rst)
    rd_req && $past(state_q) == ST_DELAY |-> chk_gap_q >= GAP_W'(WAIT_CYCLES));
  assert_first_probe_R8: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> rd_req && rd_phy == '0 && rd_reg == REG_ID_LO);
  assert_result_idle_R9: assert property (@(posedge clk) disable iff (rst)
    found |-> !busy);
endmodule

// File: rtl/phy_scan.sv
module phy_scan #(
  parameter int CLK_HZ     = 125000000,
  parameter int WAIT_US    = 10000,
  parameter int MAX_PASSES = 11,
  parameter int WAIT_CYCLES_OVR = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        found,
  output logic [4:0]  phy_addr,
  output logic [31:0] phy_id,
  output logic        rd_req,
  output logic [4:0]  rd_phy,
  output logic [4:0]  rd_reg,
  input  logic        rd_done,
  input  logic [15:0] rd_data
);
  localparam int ADDR_W = 5;
  localparam longint WAIT_CALC = (longint'(CLK_HZ) * WAIT_US) / 1000000;
  localparam int WAIT_CYCLES = (WAIT_CYCLES_OVR > 0) ? WAIT_CYCLES_OVR :
                               ((WAIT_CALC < 1) ? 1 : int'(WAIT_CALC));

  logic load_wait;
  logic expired;

  phy_scan_delay #(.WAIT_CYCLES(WAIT_CYCLES)) u_delay (
    .clk(clk), .rst(rst), .load(load_wait), .expired(expired)
  );

  phy_scan_ctrl #(
    .ADDR_W(ADDR_W), .MAX_PASSES(MAX_PASSES), .WAIT_CYCLES(WAIT_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .expired(expired), .load_wait(load_wait),
    .busy(busy), .done(done), .found(found), .phy_addr(phy_addr), .phy_id(phy_id),
    .rd_req(rd_req), .rd_phy(rd_phy), .rd_reg(rd_reg),
    .rd_done(rd_done), .rd_data(rd_data)
  );
endmodule

// File: tb/phy_scan_tb.sv
module phy_scan_tb;
  localparam int W   = 20;
  localparam int MAXP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, found, rd_req, rd_done;
  logic [4:0] phy_addr, rd_phy, rd_reg;
  logic [31:0] phy_id;
  logic [15:0] rd_data;

  always #4 clk = ~clk;

  phy_scan #(.MAX_PASSES(MAXP), .WAIT_CYCLES_OVR(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .found(found),
    .phy_addr(phy_addr), .phy_id(phy_id), .rd_req(rd_req), .rd_phy(rd_phy),
    .rd_reg(rd_reg), .rd_done(rd_done), .rd_data(rd_data)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // PHY model behind the MDIO engine
  bit          pres [32];
  int          appear [32];
  logic [15:0] lo_v [32];
  logic [15:0] hi_v [32];
  int          pass_seen;
  int          pend;
  logic [4:0]  cap_phy, cap_reg;
  logic [4:0]  log_phy [256];
  logic [4:0]  log_reg [256];
  int          nlog;
  int          cyc, t_last_done, gap_min, gap_max, ngaps;

  initial begin
    rd_done = 1'b0; rd_data = '0; pend = 0; nlog = 0; pass_seen = 0; cyc = 0;
    cap_phy = '0; cap_reg = '0;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    rd_done <= 1'b0;
    if (rd_req) begin
      cap_phy = rd_phy; cap_reg = rd_reg;
      if (nlog < 256) begin log_phy[nlog] = rd_phy; log_reg[nlog] = rd_reg; end
      nlog = nlog + 1;
      if (rd_phy == 0 && rd_reg == 3) begin
        pass_seen = pass_seen + 1;
        if (pass_seen > 1) begin
          if (cyc - t_last_done < gap_min) gap_min = cyc - t_last_done;
          if (cyc - t_last_done > gap_max) gap_max = cyc - t_last_done;
          ngaps = ngaps + 1;
        end
      end
      pend = 2;
    end else if (pend == 1) begin
      rd_done <= 1'b1;
      t_last_done = cyc;
      if (pres[cap_phy] && pass_seen >= appear[cap_phy])
        rd_data <= (cap_reg == 5'd3) ? lo_v[cap_phy] : hi_v[cap_phy];
      else
        rd_data <= 16'hFFFF;
      pend = 0;
    end else if (pend > 1) begin
      pend = pend - 1;
    end
  end

  task automatic clear_phys();
    for (int i = 0; i < 32; i++) begin
      pres[i] = 1'b0; appear[i] = 1; lo_v[i] = 16'h0; hi_v[i] = 16'h0;
    end
  endtask

  task automatic add_phy(input int a, input int ap, input logic [15:0] hi, input logic [15:0] lo);
    pres[a] = 1'b1; appear[a] = ap; hi_v[a] = hi; lo_v[a] = lo;
  endtask

  // Runs one scan; mid_start pulses start again during the scan
  task automatic run_scan(input bit mid_start);
    int lim;
    nlog = 0; pass_seen = 0; gap_min = 1 << 30; gap_max = 0; ngaps = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(rd_req == 1'b1 && rd_phy == 5'd0 && rd_reg == 5'd3, "R8", "first request",
        {rd_req, rd_phy, rd_reg}, {1'b1, 5'd0, 5'd3});
    chk(busy == 1'b1, "R1", "busy after start", busy, 1);
    if (mid_start) begin
      repeat (10) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    lim = 0;
    while (!done && lim < 20000) begin @(negedge clk); lim++; end
    chk(done == 1'b1, "R1", "done reached", done, 1);
    chk(busy == 1'b0, "R1", "busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R1", "done one cycle", done, 0);
  endtask

  task automatic check_log(input bit hit, input int a, input int p, input string req);
    int nlo, bad;
    nlo = hit ? (p - 1) * 32 + a + 1 : MAXP * 32;
    chk(nlog == nlo + (hit ? 1 : 0), req, "read count", nlog, nlo + (hit ? 1 : 0));
    bad = 0;
    for (int i = 0; i < nlo; i++)
      if (log_phy[i] != 5'(i % 32) || log_reg[i] != 5'd3) bad++;
    chk(bad == 0, "R3", "probe order", bad, 0);
    if (hit)
      chk(log_phy[nlo] == 5'(a) && log_reg[nlo] == 5'd2, "R5", "id high read",
          {log_phy[nlo], log_reg[nlo]}, {5'(a), 5'd2});
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0 && found == 0 && rd_req == 0, "R1", "reset state",
        {busy, done, found, rd_req}, 0);
  endtask

  task automatic t_hit_mid();
    clear_phys();
    add_phy(5, 1, 16'h0022, 16'h1561);
    add_phy(9, 1, 16'hABCD, 16'h0001);
    run_scan(1'b0);
    chk(found == 1'b1 && phy_addr == 5'd5, "R9", "lowest responder", phy_addr, 5);
    chk(phy_id == 32'h0022_1561, "R5", "identifier", phy_id, 32'h0022_1561);
    check_log(1'b1, 5, 1, "R4");
    repeat (5) @(negedge clk);
    chk(found == 1'b1 && phy_id == 32'h0022_1561, "R9", "result held", phy_id, 32'h0022_1561);
  endtask

  task automatic t_hit_edges();
    clear_phys();
    add_phy(0, 1, 16'h1234, 16'h0000);
    run_scan(1'b0);
    chk(found && phy_addr == 5'd0 && phy_id == 32'h1234_0000, "R4", "hit at 0 with zero lo",
        phy_id, 32'h1234_0000);
    check_log(1'b1, 0, 1, "R4");
    clear_phys();
    add_phy(31, 1, 16'hFFFF, 16'hFFFE);
    run_scan(1'b0);
    chk(found && phy_addr == 5'd31 && phy_id == 32'hFFFF_FFFE, "R5", "hit at 31",
        phy_id, 32'hFFFF_FFFE);
    check_log(1'b1, 31, 1, "R3");
  endtask

  task automatic t_none();
    clear_phys();
    run_scan(1'b0);
    chk(found == 1'b0 && phy_addr == 5'h1F && phy_id == 0, "R6", "not-found result",
        {found, phy_addr, phy_id}, {1'b0, 5'h1F, 32'h0});
    check_log(1'b0, 0, 0, "R6");
    chk(ngaps == MAXP - 1, "R7", "pass boundaries", ngaps, MAXP - 1);
    chk(gap_min >= W && gap_max <= W + 4, "R7", "wait length", gap_min, W);
  endtask

  task automatic t_late_phy();
    clear_phys();
    add_phy(7, 2, 16'h0141, 16'h0CC2);
    add_phy(20, 1, 16'h1111, 16'h2222);
    run_scan(1'b0);
    chk(found && phy_addr == 5'd20, "R9", "first-pass responder wins", phy_addr, 20);
    clear_phys();
    add_phy(7, 2, 16'h0141, 16'h0CC2);
    run_scan(1'b0);
    chk(found && phy_addr == 5'd7 && phy_id == 32'h0141_0CC2, "R9", "hit on second pass",
        phy_id, 32'h0141_0CC2);
    check_log(1'b1, 7, 2, "R7");
    chk(ngaps == 1 && gap_min >= W, "R7", "gap before pass two", gap_min, W);
  endtask

  task automatic t_busy_start();
    clear_phys();
    add_phy(12, 1, 16'h0007, 16'h0008);
    run_scan(1'b1);
    check_log(1'b1, 12, 1, "R2");
    chk(found && phy_addr == 5'd12, "R2", "restart ignored", phy_addr, 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_hit_mid();
    t_hit_edges();
    t_none();
    t_late_phy();
    t_busy_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule